// File: doc/BRIEF.md
# Byte-Level I2C Master Core

This core is an I2C bus master that advances by exactly one bus step for each software command. A host programs a control register and a data register. The core then produces one of these steps on open-drain SCL and SDA lines: a START, a repeated START, a STOP, an address byte, a data byte sent, or a data byte received. When the step finishes, the core posts an 8-bit status code and raises an interrupt flag. It then stays parked, with the bus held, until the host clears that flag.

The bit rate comes from an external divider as a single-cycle `bit_tick` enable. Every bit on the wire takes four ticks:
- SCL low while SDA is set up,
- SCL released,
- SDA sampled,
- SCL pulled low again.

The core watches SDA whenever it releases the line to send a 1. If it reads a 0 at that point, it decides that another master has won the bus, backs off, and reports lost arbitration.

Top module: `i2cm_byte_master`

## Requirements
- R1: After `rst_n` low, or one cycle after `soft_rst` is high at a clock edge, the status reads 0xF8, the control and data registers read 0, `irq` is 0 and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: With enable (control bit 6) set and the bus not owned, setting START (control bit 5) produces a START condition (SDA falls while SCL is high). The status then becomes 0x08, IFLG (control bit 3) sets, and the START bit clears by itself.
- R3: After a START, clearing IFLG sends the data register as the address byte, most significant bit first. Bits [7:1] carry the 7-bit address and bit 0 carries the direction (1 = read). The resulting status is 0x18 or 0x20 for a write address that is acknowledged or not, and 0x40 or 0x48 for a read address that is acknowledged or not.
- R4: After status 0x18 or 0x28, clearing IFLG transmits the data register. The status becomes 0x28 if the target acknowledges and 0x30 if it does not.
- R5: After status 0x40 or 0x50, clearing IFLG receives one byte, most significant bit first, into the data register. The core answers with ACK (SDA low) when control bit 2 is 1, giving status 0x50. It answers with NACK (SDA released) when that bit is 0, giving status 0x58.
- R6: While IFLG is set, the bus lines and the status do not change. Writing 1 to IFLG never sets it. Writing 0 to IFLG is the trigger for the next step.
- R7: If START is set while IFLG is still set during an owned transfer, a repeated START is issued once IFLG is cleared. The status then becomes 0x10.
- R8: With the bus owned and IFLG clear, setting STOP (control bit 4) produces a STOP condition (SDA rises while SCL is high). The STOP bit then clears by itself, the status returns to 0xF8, both lines are released and IFLG stays clear.
- R9: If the core releases SDA for a 1 during an address or data bit and samples SDA low, it releases both lines, posts status 0x38 and sets IFLG. Nothing further happens until IFLG is cleared, after which the status returns to 0xF8.
- R10: `irq` is high exactly when IFLG and interrupt-enable (control bit 7) are both 1.
- R11: While enable (control bit 6) is 0, no bus step is started, even if START is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous return to idle |
| bit_tick | input | 1 | Quarter-bit enable from the rate divider |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write value |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 8 | Data write value (byte to send, or address and direction) |
| ctrl_rdata | output | 8 | Control register contents |
| data_rdata | output | 8 | Data register contents (last received byte after a read) |
| status_code | output | 8 | Code of the last completed step |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Resolved level of the SDA wire |

## Verification
The properties assume three things about the host:
- It writes the control and data registers only while IFLG is set or the core is idle.
- It clears START or STOP through a control write only while no step is running.
- It releases soft reset after a single cycle.

The stimulus meets these assumptions by polling IFLG, or the STOP bit, before every register write. The bench also models the target on the wire. That model decodes START and STOP and counts SCL edges. It drives acknowledge and read data, and it can deliberately pull a bit low to force lost arbitration.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    // control register bit positions (software visible)
    localparam int CB_ACK   = 2;
    localparam int CB_IFLG  = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_EN    = 6;
    localparam int CB_IEN   = 7;

    localparam logic [7:0] ST_START   = 8'h08;
    localparam logic [7:0] ST_RSTART  = 8'h10;
    localparam logic [7:0] ST_AW_ACK  = 8'h18;
    localparam logic [7:0] ST_AW_NAK  = 8'h20;
    localparam logic [7:0] ST_DW_ACK  = 8'h28;
    localparam logic [7:0] ST_DW_NAK  = 8'h30;
    localparam logic [7:0] ST_ARB     = 8'h38;
    localparam logic [7:0] ST_AR_ACK  = 8'h40;
    localparam logic [7:0] ST_AR_NAK  = 8'h48;
    localparam logic [7:0] ST_DR_ACK  = 8'h50;
    localparam logic [7:0] ST_DR_NAK  = 8'h58;
    localparam logic [7:0] ST_IDLE    = 8'hF8;

    typedef enum logic [2:0] {OP_NONE, OP_START, OP_STOP, OP_WRITE, OP_READ} op_e;
    typedef enum logic [2:0] {K_START, K_RSTART, K_ADDR, K_WDATA, K_RDATA, K_STOP} step_e;
endpackage

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
    import i2cm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          tick,
    input  logic          go,
    input  op_e           op,
    input  logic [DW-1:0] tx_byte,
    input  logic          ack_drive,
    input  logic          sda_i,
    output logic          done,
    output logic          arb_lost,
    output logic          ack_seen,
    output logic [DW-1:0] rx_byte,
    output logic          scl_oe,
    output logic          sda_oe
);
    localparam int BW = $clog2(DW + 1);

    typedef struct packed {
        logic          active;
        op_e           op;
        logic [1:0]    qtr;
        logic [BW-1:0] bitn;
        logic [DW-1:0] sh;
        logic          ackd;
        logic          scl_low;
        logic          sda_low;
        logic          done;
        logic          arb;
        logic          acked;
    } eng_s;

    eng_s q, n;
    logic last, wr;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        n.arb  = 1'b0;
        last   = (q.bitn == BW'(DW));
        wr     = (q.op == OP_WRITE);
        if (!q.active) begin
            if (go) begin
                n.active = 1'b1;
                n.op     = op;
                n.qtr    = 2'd0;
                n.bitn   = '0;
                n.sh     = tx_byte;
                n.ackd   = ack_drive;
            end
        end else if (tick) begin
            n.qtr = q.qtr + 2'd1;
            case (q.op)
                OP_START: begin
                    case (q.qtr)
                        2'd0: n.sda_low = 1'b0;
                        2'd1: n.scl_low = 1'b0;
                        2'd2: n.sda_low = 1'b1;
                        default: begin n.scl_low = 1'b1; n.active = 1'b0; n.done = 1'b1; end
                    endcase
                end
                OP_STOP: begin
                    case (q.qtr)
                        2'd0: n.sda_low = 1'b1;
                        2'd1: n.scl_low = 1'b0;
                        2'd2: n.sda_low = 1'b0;
                        default: begin n.active = 1'b0; n.done = 1'b1; end
                    endcase
                end
                default: begin
                    case (q.qtr)
                        2'd0: begin
                            n.scl_low = 1'b1;
                            n.sda_low = wr ? (!last && !q.sh[DW-1]) : (last && q.ackd);
                        end
                        2'd1: n.scl_low = 1'b0;
                        2'd2: begin
                            if (wr && !last && q.sh[DW-1] && !sda_i) begin
                                n.scl_low = 1'b0;
                                n.sda_low = 1'b0;
                                n.active  = 1'b0;
                                n.done    = 1'b1;
                                n.arb     = 1'b1;
                            end else if (last) begin
                                n.acked = !sda_i;
                            end else begin
                                n.sh = {q.sh[DW-2:0], sda_i};
                            end
                        end
                        default: begin
                            n.scl_low = 1'b1;
                            if (last) begin
                                n.active = 1'b0;
                                n.done   = 1'b1;
                            end else begin
                                n.bitn = q.bitn + BW'(1);
                            end
                        end
                    endcase
                end
            endcase
        end
        if (srst) n = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done     = q.done;
    assign arb_lost = q.arb;
    assign ack_seen = q.acked;
    assign rx_byte  = q.sh;
    assign scl_oe   = q.scl_low;
    assign sda_oe   = q.sda_low;
endmodule

// File: rtl/i2cm_status_enc.sv
module i2cm_status_enc
    import i2cm_pkg::*;
(
    input  step_e       kind,
    input  logic        dir_read,
    input  logic        acked,
    input  logic        ack_sent,
    input  logic        arb,
    output logic [7:0]  code
);
    always_comb begin
        if (arb) begin
            code = ST_ARB;
        end else begin
            case (kind)
                K_START:  code = ST_START;
                K_RSTART: code = ST_RSTART;
                K_ADDR:   code = dir_read ? (acked ? ST_AR_ACK : ST_AR_NAK)
                                          : (acked ? ST_AW_ACK : ST_AW_NAK);
                K_WDATA:  code = acked ? ST_DW_ACK : ST_DW_NAK;
                K_RDATA:  code = ack_sent ? ST_DR_ACK : ST_DR_NAK;
                default:  code = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_byte_master.sv
module i2cm_byte_master
    import i2cm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          bit_tick,
    input  logic          ctrl_we,
    input  logic [7:0]    ctrl_wdata,
    input  logic          data_we,
    input  logic [DW-1:0] data_wdata,
    output logic [7:0]    ctrl_rdata,
    output logic [DW-1:0] data_rdata,
    output logic [7:0]    status_code,
    output logic          irq,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          sda_i
);
    typedef struct packed {
        logic [7:0]    ctrl;
        logic [DW-1:0] data;
        logic [7:0]    status;
        logic          owned;
        logic          busy;
        step_e         kind;
        logic          ackl;
    } top_s;

    localparam top_s RST_VAL = '{ctrl: 8'h00, data: '0, status: ST_IDLE,
                                 owned: 1'b0, busy: 1'b0, kind: K_START, ackl: 1'b0};

    top_s q, n;
    logic go;
    op_e op;
    logic eng_done, eng_arb, eng_acked;
    logic [DW-1:0] eng_rx;
    logic [7:0] enc_code;

    i2cm_bit_engine #(.DW(DW)) eng_i (
        .clk(clk), .rst_n(rst_n), .srst(soft_rst), .tick(bit_tick),
        .go(go), .op(op), .tx_byte(q.data), .ack_drive(q.ctrl[CB_ACK]),
        .sda_i(sda_i), .done(eng_done), .arb_lost(eng_arb), .ack_seen(eng_acked),
        .rx_byte(eng_rx), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    i2cm_status_enc enc_i (
        .kind(q.kind), .dir_read(q.data[0]), .acked(eng_acked),
        .ack_sent(q.ackl), .arb(eng_arb), .code(enc_code)
    );

    always_comb begin
        n  = q;
        go = 1'b0;
        op = OP_NONE;
        if (ctrl_we) begin
            n.ctrl          = ctrl_wdata;
            n.ctrl[CB_IFLG] = q.ctrl[CB_IFLG] & ctrl_wdata[CB_IFLG];
        end
        if (data_we) n.data = data_wdata;

        if (q.busy) begin
            if (eng_done) begin
                n.busy   = 1'b0;
                n.status = enc_code;
                if (q.kind == K_STOP) begin
                    n.ctrl[CB_STOP] = 1'b0;
                    n.owned         = 1'b0;
                end else begin
                    n.ctrl[CB_IFLG] = 1'b1;
                    n.owned         = !eng_arb;
                    if (q.kind == K_START || q.kind == K_RSTART) n.ctrl[CB_START] = 1'b0;
                    if (q.kind == K_RDATA && !eng_arb) n.data = eng_rx;
                end
            end
        end else if (!q.ctrl[CB_IFLG]) begin
            if (!q.owned) n.status = ST_IDLE;
            if (q.ctrl[CB_EN]) begin
                if (!q.owned) begin
                    if (q.ctrl[CB_START]) begin go = 1'b1; op = OP_START; n.kind = K_START; end
                end else if (q.ctrl[CB_STOP]) begin
                    go = 1'b1; op = OP_STOP; n.kind = K_STOP;
                end else if (q.ctrl[CB_START]) begin
                    go = 1'b1; op = OP_START; n.kind = K_RSTART;
                end else begin
                    case (q.status)
                        ST_START, ST_RSTART: begin go = 1'b1; op = OP_WRITE; n.kind = K_ADDR;  end
                        ST_AW_ACK, ST_DW_ACK: begin go = 1'b1; op = OP_WRITE; n.kind = K_WDATA; end
                        ST_AR_ACK, ST_DR_ACK: begin go = 1'b1; op = OP_READ;  n.kind = K_RDATA; end
                        default: ;
                    endcase
                end
            end
            if (go) begin
                n.busy = 1'b1;
                n.ackl = q.ctrl[CB_ACK];
            end
        end
        if (soft_rst) n = RST_VAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= n;
    end

    assign ctrl_rdata  = q.ctrl;
    assign data_rdata  = q.data;
    assign status_code = q.status;
    assign irq         = q.ctrl[CB_IFLG] & q.ctrl[CB_IEN];
endmodule

// File: rtl/i2cm_byte_master_chk.sv
module i2cm_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       ctrl_we,
    input logic [7:0] ctrl_rdata,
    input logic [7:0] status_code,
    input logic       scl_oe,
    input logic       sda_oe
);
    // R1: soft reset returns to idle with lines released
    a_r1_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (status_code == 8'hF8 && !scl_oe && !sda_oe && ctrl_rdata == 8'h00));

    // R2: START bit drops by itself only with a start status posted
    a_r2_start_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctrl_rdata[5]) && !$past(ctrl_we) && !$past(soft_rst))
        |-> (status_code == 8'h08 || status_code == 8'h10));

    // R6: nothing moves on the bus while the flag stays set
    a_r6_stall_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[3] && $past(ctrl_rdata[3]))
        |-> ($stable(scl_oe) && $stable(sda_oe) && $stable(status_code)));

    // R6: a set flag always comes with a non-idle status
    a_r6_iflg_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[3] |-> (status_code != 8'hF8));

    // R8: STOP bit drops by itself only once the bus is free again
    a_r8_stop_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctrl_rdata[4]) && !$past(ctrl_we) && !$past(soft_rst))
        |-> (status_code == 8'hF8 && !scl_oe && !sda_oe));

    // R9: after lost arbitration both lines stay released
    a_r9_arb_released: assert property (@(posedge clk) disable iff (!rst_n)
        (status_code == 8'h38) |-> (!scl_oe && !sda_oe));
endmodule

bind i2cm_byte_master i2cm_byte_master_chk chk_i (.*);

// File: tb/i2cm_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2cm_byte_master_tb_top;
    localparam logic [7:0] C_ACK = 8'h04, C_IFLG = 8'h08, C_STOP = 8'h10,
                           C_START = 8'h20, C_EN = 8'h40, C_IEN = 8'h80;
    localparam logic [7:0] BASE = C_EN | C_IEN;

    logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, bit_tick = 1'b0;
    logic ctrl_we = 1'b0, data_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00, data_wdata = 8'h00;
    logic [7:0] ctrl_rdata, data_rdata, status_code;
    logic irq, scl_oe, sda_oe;
    logic scl_bus, sda_bus, slv_pull;

    int checks = 0, fails = 0;

    // target model state
    int bcnt = -1;
    logic pv_scl = 1'b1, pv_sda = 1'b1;
    logic [7:0] sh_in = 8'h00, slv_rx = 8'h00, drv_byte = 8'hFF;
    logic slv_mack = 1'b1, drv_ack = 1'b0;
    int start_seen = 0, stop_seen = 0;

    always #2.5 clk = ~clk;

    i2cm_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bit_tick(bit_tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .data_we(data_we), .data_wdata(data_wdata),
        .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata), .status_code(status_code),
        .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_bus)
    );

    function automatic logic pull_f(int c, logic [7:0] b, logic a);
        if (c < 0) return 1'b0;
        if ((c % 9) == 8) return a;
        return ~b[7 - (c % 9)];
    endfunction

    assign slv_pull = pull_f(bcnt, drv_byte, drv_ack);
    assign scl_bus  = ~scl_oe;
    assign sda_bus  = ~(sda_oe | slv_pull);

    // quarter-bit tick every 4 clocks
    initial begin
        int tc;
        tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % 4;
            bit_tick = (tc == 0);
        end
    end

    // target on the wire
    initial forever begin
        @(negedge clk);
        if (pv_scl && scl_bus && pv_sda && !sda_bus) begin
            bcnt = -1; start_seen++;
        end else if (pv_scl && scl_bus && !pv_sda && sda_bus) begin
            stop_seen++;
        end else if (!pv_scl && scl_bus && bcnt >= 0) begin
            if ((bcnt % 9) == 8) begin slv_rx = sh_in; slv_mack = sda_bus; end
            else sh_in = {sh_in[6:0], sda_bus};
        end else if (pv_scl && !scl_bus) begin
            bcnt++;
        end
        pv_scl = scl_bus;
        pv_sda = sda_bus;
    end

    // watchdog
    initial begin
        repeat (150000) @(negedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic [7:0] exp_addr(logic rd, logic ak);
        if (rd) return ak ? 8'h40 : 8'h48;
        return ak ? 8'h18 : 8'h20;
    endfunction
    function automatic logic [7:0] exp_wr(logic ak);
        return ak ? 8'h28 : 8'h30;
    endfunction
    function automatic logic [7:0] exp_rd(logic ak);
        return ak ? 8'h50 : 8'h58;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask
    task automatic wr_data(logic [7:0] v);
        @(negedge clk); data_we = 1'b1; data_wdata = v;
        @(negedge clk); data_we = 1'b0;
    endtask
    task automatic wait_flag(string req);
        int k;
        k = 0;
        while (!ctrl_rdata[3] && k < 3000) begin @(negedge clk); k++; end
        chk({req, " flag raised"}, ctrl_rdata[3], 1'b1);
    endtask
    task automatic do_stop();
        int k, s0;
        s0 = stop_seen; k = 0;
        drv_byte = 8'hFF; drv_ack = 1'b0;
        wr_ctrl(BASE | C_ACK | C_STOP);
        while (ctrl_rdata[4] && k < 3000) begin @(negedge clk); k++; end
        repeat (2) @(negedge clk);
        chk("R8 stop bit cleared", ctrl_rdata[4], 1'b0);
        chk("R8 idle status", status_code, 8'hF8);
        chk("R8 flag stays clear", ctrl_rdata[3], 1'b0);
        chk("R8 lines released", {scl_oe, sda_oe}, 2'b00);
        chk("R8 stop on bus", stop_seen, s0 + 1);
    endtask
    task automatic do_start(logic [7:0] cbase);
        int s0;
        s0 = start_seen;
        drv_byte = 8'hFF; drv_ack = 1'b0;
        wr_ctrl(cbase | C_ACK | C_START);
        wait_flag("R2");
        chk("R2 start status", status_code, 8'h08);
        chk("R2 start bit self-cleared", ctrl_rdata[5], 1'b0);
        chk("R2 start on bus", start_seen, s0 + 1);
    endtask

    initial begin
        logic [7:0] b;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status_code, 8'hF8);
        chk("R1 reset ctrl", ctrl_rdata, 8'h00);
        chk("R1 reset data", data_rdata, 8'h00);
        chk("R1 reset lines/irq", {scl_oe, sda_oe, irq}, 3'b000);

        // R11: START without enable does nothing
        wr_ctrl(C_START | C_IEN);
        repeat (200) @(negedge clk);
        chk("R11 no step while disabled", {status_code, scl_oe, sda_oe}, {8'hF8, 2'b00});
        chk("R11 start bit still pending", ctrl_rdata[5], 1'b1);
        wr_ctrl(8'h00);

        // R6: writing 1 to the flag cannot set it
        wr_ctrl(C_EN | C_IFLG);
        @(negedge clk);
        chk("R6 flag not settable", ctrl_rdata[3], 1'b0);

        // random transactions
        for (int t = 0; t < 8; t++) begin
            logic [6:0] addr;
            logic rd, aack;
            int nb;
            addr = 7'($urandom % 128);
            rd   = 1'($urandom % 2);
            aack = (($urandom % 4) != 0);
            nb   = 1 + int'($urandom % 3);
            do_start(BASE);
            chk("R10 irq with enable", irq, 1'b1);
            wr_data({addr, rd});
            drv_ack = aack;
            wr_ctrl(BASE | C_ACK);
            wait_flag("R3");
            chk("R3 address status", status_code, exp_addr(rd, aack));
            chk("R3 address byte on bus", slv_rx, {addr, rd});
            if (t == 0) begin
                logic [9:0] snap;
                snap = {scl_oe, sda_oe, status_code};
                repeat (100) @(negedge clk);
                chk("R6 stalled while flag set", {scl_oe, sda_oe, status_code}, snap);
            end
            drv_ack = 1'b0;
            if (aack && !rd) begin
                for (int i = 0; i < nb; i++) begin
                    logic ak;
                    b  = 8'($urandom);
                    ak = (($urandom % 4) != 0);
                    wr_data(b);
                    drv_ack = ak;
                    wr_ctrl(BASE | C_ACK);
                    wait_flag("R4");
                    chk("R4 write status", status_code, exp_wr(ak));
                    chk("R4 byte on bus", slv_rx, b);
                    drv_ack = 1'b0;
                    if (!ak) break;
                end
            end else if (aack && rd) begin
                for (int i = 0; i < nb; i++) begin
                    logic lst;
                    lst = (i == nb - 1);
                    b = 8'($urandom);
                    drv_byte = b;
                    wr_ctrl(BASE | (lst ? 8'h00 : C_ACK));
                    wait_flag("R5");
                    chk("R5 read status", status_code, exp_rd(!lst));
                    chk("R5 read data", data_rdata, b);
                    chk("R5 ack level driven", slv_mack, lst);
                    drv_byte = 8'hFF;
                end
            end
            do_stop();
        end

        // R7 repeated START, R10 irq gated off
        do_start(C_EN);
        chk("R10 irq masked", irq, 1'b0);
        wr_data({7'h50, 1'b0});
        drv_ack = 1'b1;
        wr_ctrl(C_EN | C_ACK);
        wait_flag("R3");
        chk("R3 write address acked", status_code, 8'h18);
        wr_data(8'hA5);
        wr_ctrl(C_EN | C_ACK);
        wait_flag("R4");
        chk("R4 data acked", status_code, 8'h28);
        drv_ack = 1'b0;
        wr_ctrl(C_EN | C_ACK | C_START | C_IFLG);
        repeat (60) @(negedge clk);
        chk("R7 held until flag cleared", {ctrl_rdata[3], status_code}, {1'b1, 8'h28});
        begin
            int s0;
            s0 = start_seen;
            wr_ctrl(C_EN | C_ACK | C_START);
            wait_flag("R7");
            chk("R7 repeated start status", status_code, 8'h10);
            chk("R7 repeated start on bus", start_seen, s0 + 1);
        end
        wr_data({7'h50, 1'b1});
        drv_ack = 1'b1;
        wr_ctrl(C_EN | C_ACK);
        wait_flag("R3");
        chk("R3 read address acked", status_code, 8'h40);
        drv_ack = 1'b0; drv_byte = 8'h3C;
        wr_ctrl(C_EN);
        wait_flag("R5");
        chk("R5 final byte nack", status_code, 8'h58);
        chk("R5 final byte data", data_rdata, 8'h3C);
        do_stop();

        // R9 lost arbitration
        do_start(BASE);
        wr_data(8'hFF);
        drv_byte = 8'hF7;
        wr_ctrl(BASE | C_ACK);
        wait_flag("R9");
        chk("R9 arbitration status", status_code, 8'h38);
        chk("R9 lines released", {scl_oe, sda_oe}, 2'b00);
        repeat (80) @(negedge clk);
        chk("R9 no action until cleared", {status_code, scl_oe, sda_oe}, {8'h38, 2'b00});
        drv_byte = 8'hFF;
        wr_ctrl(BASE | C_ACK);
        repeat (3) @(negedge clk);
        chk("R9 idle after clear", status_code, 8'hF8);

        // R1 soft reset mid byte
        do_start(BASE);
        wr_data(8'h3C);
        wr_ctrl(BASE | C_ACK);
        repeat (60) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk("R1 soft reset status", status_code, 8'hF8);
        chk("R1 soft reset regs", {ctrl_rdata, data_rdata}, 16'h0000);
        chk("R1 soft reset lines", {scl_oe, sda_oe}, 2'b00);
        repeat (20) @(negedge clk);
        do_start(BASE);
        do_stop();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule